// File: doc/BRIEF.md
# DMA Channel Terminal Count Controller

This block holds the transfer count and the termination rules for one DMA channel. Software loads a 16-bit count and a small control word through a register write port, and reads either of them back through a read port. The bus side of the channel reports each finished transfer with a one-cycle strobe. On each strobe the block decrements the count. It then decides whether the channel stays armed and whether to request an interrupt.

Termination depends on the synchronization mode. A synchronized channel stops at zero only when its terminal-count enable is set. Without it, the channel keeps running and the count wraps. A software-initiated (unsynchronized) channel always stops when the count reaches zero. An interrupt request needs both the terminal-count enable and the interrupt enable. Address generation, bus cycles, arbitration between channels and interrupt handling lie outside this block.

Top module: `dmatc_channel`

## Requirements
- R1: Write address 0 selects the count and address 1 the control word. The control word bits are [0] start (armed), [1] terminal-count enable, [2] interrupt enable and [3] synchronized mode (1 = synchronized, 0 = software-initiated). Upper control bits are discarded and read as 0. After reset the control word is 0 and the count holds the fixed pattern RST_COUNT, which software must overwrite before arming.
- R2: Each accepted transfer strobe lowers the count by exactly one, modulo 2^16. A strobe is accepted when `xfer_done` is high, start is set and no count write occurs in the same cycle.
- R3: A transfer strobe while start is clear changes neither the count nor any other state.
- R4: With terminal-count enable set, start clears at the same clock edge at which an accepted transfer brings the count from 1 to 0.
- R5: In synchronized mode with terminal-count enable clear, the channel stays armed through zero. The next accepted transfer wraps the count to 0xFFFF.
- R6: In software-initiated mode, start always clears when an accepted transfer brings the count to 0, whatever the value of the terminal-count enable.
- R7: `tc_irq` is a one-cycle pulse in the cycle after an accepted transfer brings the count to 0. It is raised only when terminal-count enable and interrupt enable are both set.
- R8: A count write in the same cycle as a transfer strobe wins. The count takes the written value and that transfer is discarded.
- R9: A control write in the same cycle as an automatic clear wins. Start takes the written value.
- R10: Leaving zero never disarms the channel. A count programmed to 0 therefore yields exactly 65,536 accepted transfers before a terminating channel disarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 count, 1 control |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read source: 0 count, 1 control |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| xfer_done | input | 1 | One-cycle pulse per completed transfer |
| armed | output | 1 | Current start bit |
| tc_irq | output | 1 | Terminal-count interrupt request pulse |

## Verification
A transfer strobe can land in the same cycle as a software write: a count write against the decrement, or a control write against the automatic clear at zero. The bench provokes both collisions directly by raising `xfer_done` together with `wr_en`. A behavioural model applies the write-wins rule, and its count, start bit and interrupt pulse are compared with the ports on every clock. Collisions between a count write and the final transfer are also driven, to confirm that no interrupt or disarm follows a discarded strobe.

// File: rtl/dmatc_pkg.sv
// Package: shared types for the DMA terminal-count controller.
// Assumes a single control word with the field order below (bit 0 first).
package dmatc_pkg;
    localparam int CTRL_W = 4;

    typedef enum logic {
        ADDR_COUNT = 1'b0,
        ADDR_CTRL  = 1'b1
    } reg_addr_e;

    // Packed so that start lands in bit 0 and sync in bit 3.
    typedef struct packed {
        logic sync;
        logic irq_en;
        logic tc_en;
        logic start;
    } ctrl_t;
endpackage

// File: rtl/dmatc_ctrl_reg.sv
// Module: dmatc_ctrl_reg
// Holds the control word. A software write has priority over the automatic
// clear of the start bit requested by the termination logic.
// Assumes auto_clr is a single-cycle request.
module dmatc_ctrl_reg
    import dmatc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              auto_clr,
    output ctrl_t             ctrl_q
);
    // Control word update: reset, then write, then automatic disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_t'(ctrl_wdata);
        end else if (auto_clr) begin
            ctrl_q.start <= 1'b0;
        end
    end

    // R9
    // A control write must land even when an automatic clear is requested.
    ctrl_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_q == ctrl_t'($past(ctrl_wdata)));

    // R3
    // Without a write or an automatic clear, the control word holds.
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && !auto_clr) |=> $stable(ctrl_q));
endmodule

// File: rtl/dmatc_counter.sv
// Module: dmatc_counter
// Transfer count register with load and modulo decrement, plus an early
// "about to reach zero" flag. A load has priority over a decrement.
// Assumes dec_en and load are single-cycle qualifiers from the caller.
module dmatc_counter #(
    parameter int              CNT_W     = 16,
    parameter logic [CNT_W-1:0] RST_COUNT = 16'hC3A5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count update: reset pattern, load, or decrement with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_COUNT;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec_en) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Flags the count value that the next decrement will turn into zero.
    always_comb begin
        at_one = (cnt_q == ONE);
    end

    // R2
    dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load) |=> cnt_q == $past(cnt_q) - ONE);

    // R8
    load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/dmatc_term.sv
// Module: dmatc_term
// Decides whether a transfer strobe is accepted, whether the channel disarms
// at zero, and whether a terminal-count interrupt pulse is raised.
// Assumes xfer_done is a one-cycle pulse per completed transfer.
module dmatc_term
    import dmatc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_q,
    input  logic  xfer_done,
    input  logic  cnt_load,
    input  logic  at_one,
    output logic  dec_en,
    output logic  auto_clr,
    output logic  tc_irq
);
    logic hit_zero;

    // Acceptance and termination decisions for the current strobe.
    always_comb begin
        dec_en   = xfer_done && ctrl_q.start && !cnt_load;
        hit_zero = dec_en && at_one;
        auto_clr = hit_zero && (ctrl_q.tc_en || !ctrl_q.sync);
    end

    // Interrupt pulse, registered one cycle after the decrement to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_irq <= 1'b0;
        end else begin
            tc_irq <= hit_zero && ctrl_q.tc_en && ctrl_q.irq_en;
        end
    end

    // R7
    irq_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |-> ($past(ctrl_q.tc_en) && $past(ctrl_q.irq_en)));

    // R7
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |=> !tc_irq);

    // R3
    no_accept_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.start |-> !dec_en);
endmodule

// File: rtl/dmatc_channel.sv
// Module: dmatc_channel (top)
// Transfer count and termination control for one DMA channel, with a
// register write/read port and a transfer-done strobe.
// Assumes software loads the count before arming; the reset count is a
// fixed pattern with no meaning.
module dmatc_channel
    import dmatc_pkg::*;
#(
    parameter int               CNT_W     = 16,
    parameter logic [CNT_W-1:0] RST_COUNT = 16'hC3A5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             xfer_done,
    output logic             armed,
    output logic             tc_irq
);
    localparam int PAD_W = CNT_W - CTRL_W;

    logic             cnt_we;
    logic             ctrl_we;
    logic             dec_en;
    logic             auto_clr;
    logic             at_one;
    logic [CNT_W-1:0] cnt_q;
    ctrl_t            ctrl_q;

    // Write decode onto the two registers.
    always_comb begin
        cnt_we  = wr_en && (reg_addr_e'(wr_addr) == ADDR_COUNT);
        ctrl_we = wr_en && (reg_addr_e'(wr_addr) == ADDR_CTRL);
    end

    // Read mux; unused control bits read as zero.
    always_comb begin
        if (reg_addr_e'(rd_addr) == ADDR_CTRL) begin
            rd_data = {{PAD_W{1'b0}}, ctrl_q};
        end else begin
            rd_data = cnt_q;
        end
        armed = ctrl_q.start;
    end

    dmatc_ctrl_reg i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (wr_data[CTRL_W-1:0]),
        .auto_clr   (auto_clr),
        .ctrl_q     (ctrl_q)
    );

    dmatc_counter #(
        .CNT_W     (CNT_W),
        .RST_COUNT (RST_COUNT)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_we),
        .load_val (wr_data),
        .dec_en   (dec_en),
        .cnt_q    (cnt_q),
        .at_one   (at_one)
    );

    dmatc_term i_term (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_q    (ctrl_q),
        .xfer_done (xfer_done),
        .cnt_load  (cnt_we),
        .at_one    (at_one),
        .dec_en    (dec_en),
        .auto_clr  (auto_clr),
        .tc_irq    (tc_irq)
    );

    // R4
    tc_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && xfer_done && !wr_en && ctrl_q.tc_en && cnt_q == CNT_W'(1))
        |=> !armed);

    // R6
    unsync_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && xfer_done && !wr_en && !ctrl_q.sync && cnt_q == CNT_W'(1))
        |=> !armed);

    // R5
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ctrl_q.sync && !ctrl_q.tc_en && !ctrl_we) |=> armed);

    // R10
    leave_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && xfer_done && !wr_en && cnt_q == '0)
        |=> (armed && cnt_q == '1));

    // R7
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |-> cnt_q == '0);
endmodule

// File: tb/test_dmatc_channel.sv
module test_dmatc_channel;
    localparam logic [15:0] RSTV = 16'hC3A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [15:0] rd_data;
    logic        xfer_done = 1'b0;
    logic        armed;
    logic        tc_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_cnt, m_start, m_tc, m_ie, m_sync, m_irq;

    dmatc_channel #(.CNT_W(16), .RST_COUNT(RSTV)) i_dmatc_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .xfer_done(xfer_done), .armed(armed), .tc_irq(tc_irq)
    );

    always #10 clk = ~clk;

    // Reference model: inputs are stable at the rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = RSTV; m_start = 0; m_tc = 0; m_ie = 0; m_sync = 0; m_irq = 0;
        end else begin
            automatic bit cwr = wr_en && !wr_addr;
            automatic bit kwr = wr_en && wr_addr;
            automatic bit go = xfer_done && (m_start != 0) && !cwr;
            automatic bit stop = 0;
            m_irq = 0;
            if (cwr) m_cnt = wr_data;
            else if (go) begin
                m_cnt = (m_cnt + 65535) % 65536;
                if (m_cnt == 0) begin
                    if (m_tc != 0 || m_sync == 0) stop = 1;
                    if (m_tc != 0 && m_ie != 0) m_irq = 1;
                end
            end
            if (kwr) begin
                m_start = wr_data[0]; m_tc = wr_data[1];
                m_ie = wr_data[2]; m_sync = wr_data[3];
            end else if (stop) m_start = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int m_ctrl();
        return m_start + 2 * m_tc + 4 * m_ie + 8 * m_sync;
    endfunction

    // One clock, then compare all outputs with the model.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        chk(armed == m_start[0], cur_req, "armed", armed, m_start);
        chk(tc_irq == m_irq[0], cur_req, "tc_irq", tc_irq, m_irq);
        if (rd_addr) chk(rd_data == 16'(m_ctrl()), cur_req, "ctrl", rd_data, m_ctrl());
        else         chk(rd_data == 16'(m_cnt), cur_req, "count", rd_data, m_cnt);
        rd_addr = ~rd_addr;
    endtask

    task automatic wr(input bit a, input logic [15:0] d, input bit xd);
        wr_en = 1'b1; wr_addr = a; wr_data = d; xfer_done = xd;
        tick();
        wr_en = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_done = 1'b1;
            tick();
        end
        xfer_done = 1'b0;
    endtask

    task automatic peek(input bit a, input int exp, input string req);
        automatic logic keep = rd_addr;
        rd_addr = a;
        #1;
        chk(rd_data == 16'(exp), req, a ? "ctrl read" : "count read", rd_data, exp);
        rd_addr = keep;
    endtask

    // Watchdog
    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        cur_req = "R1";
        peek(0, RSTV, "R1");
        peek(1, 0, "R1");
        chk(!armed && !tc_irq, "R1", "reset outputs", {armed, tc_irq}, 0);
        wr(0, 16'h1234, 0);
        peek(0, 16'h1234, "R1");
        wr(1, 16'hFFF0, 0);
        peek(1, 0, "R1");

        // R3 disarmed channel ignores strobes
        cur_req = "R3";
        pulses(5);
        peek(0, 16'h1234, "R3");

        // R2, R4, R7 terminating with interrupt
        cur_req = "R4";
        wr(0, 16'd3, 0);
        wr(1, 16'hF, 0);
        pulses(2);
        peek(0, 2 - 1, "R2");
        chk(armed, "R4", "armed before zero", armed, 1);
        xfer_done = 1'b1;
        @(posedge clk); #1;
        chk(!armed, "R4", "disarm at zero edge", armed, 0);
        chk(tc_irq, "R7", "irq after zero", tc_irq, 1);
        @(negedge clk); xfer_done = 1'b0;
        tick();
        chk(!tc_irq, "R7", "irq one cycle", tc_irq, 0);

        // R7 no interrupt without enable
        cur_req = "R7";
        wr(0, 16'd2, 0);
        wr(1, 16'hB, 0);
        pulses(2);
        chk(!armed, "R4", "disarm no irq", armed, 0);
        pulses(1);

        // R5 free running synchronized channel wraps
        cur_req = "R5";
        wr(0, 16'd2, 0);
        wr(1, 16'hD, 0);
        pulses(4);
        peek(0, 16'hFFFE, "R5");
        chk(armed, "R5", "still armed", armed, 1);

        // R6 software-initiated stops regardless of tc enable
        cur_req = "R6";
        wr(0, 16'd2, 0);
        wr(1, 16'h5, 0);
        pulses(3);
        chk(!armed, "R6", "unsync disarm", armed, 0);
        peek(0, 0, "R6");
        wr(0, 16'd1, 0);
        wr(1, 16'h7, 0);
        pulses(2);

        // R8 count write beats transfer
        cur_req = "R8";
        wr(0, 16'd5, 0);
        wr(1, 16'h9, 0);
        wr(0, 16'd9, 1);
        peek(0, 9, "R8");
        wr(0, 16'd1, 0);
        wr(0, 16'd1, 1);
        peek(0, 1, "R8");

        // R9 control write beats auto clear
        cur_req = "R9";
        wr(1, 16'hB, 0);
        wr(1, 16'hB, 1);
        chk(armed, "R9", "write beats clear", armed, 1);
        peek(0, 0, "R9");

        // R10 zero programmed gives 65536 transfers
        cur_req = "R10";
        wr(0, 16'd0, 0);
        wr(1, 16'hB, 0);
        pulses(65535);
        chk(armed, "R10", "armed after 65535", armed, 1);
        peek(0, 1, "R10");
        pulses(1);
        chk(!armed, "R10", "disarm after 65536", armed, 0);
        tick();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule